// File: doc/BRIEF.md
# I2C Slave with Clock Stretching

This block is an I2C target that receives and transmits bytes for a host on the same chip. It answers to either a 7-bit or a 10-bit address, acknowledges matching address bytes and received data, and shifts bytes out to the bus controller on reads. The bus lines are open-drain. The block samples SCL and SDA on separate inputs and pulls a line low by raising its output enable.

The host sees a one-byte data buffer, an own-address register, a release bit for the clock, an address-update flag and an interrupt flag. The block holds SCL low in two cases, so that the host can act before the transfer goes on. The first case is when the hardware has cleared the release bit during a read. The second is after each 10-bit address byte of a write, where the host must rewrite the own-address register. The host frees the clock by setting the release bit or by writing the address register. SCL is then let go on the next system clock.

Bus inputs pass through a two-flop synchronizer before start, stop and edge detection. Master operation, general call and slew control are outside this block.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After synchronous reset, `scl_oe` and `sda_oe` are 0, `rel_q` is 1, `ua_q`, `irq_q` and `rw_q` are 0, and `buf_rdata` is 0.
- R2: In 7-bit mode (`ten_bit_en`=0), an address byte whose bits [7:1] equal own-address bits [6:0] is acknowledged by SDA low during the ninth clock. Bit 0 of that byte selects read (1) or write (0), and the direction is shown on `rw_q`. On a mismatch there is no ACK, and every later byte is ignored until the next START: no ACK, and no change to `buf_rdata` or `irq_q`.
- R3: After a write address is acknowledged, each data byte is taken MSB first, acknowledged, copied into the buffer and flagged by setting `irq_q`.
- R4: After a read address is acknowledged, the buffer is driven onto SDA MSB first. SDA changes only while SCL is low, and `irq_q` is set when the eighth bit has been sent.
- R5: The release bit is cleared by hardware at the end of the ACK slot of a read address, and at the end of the ACK slot of a byte the controller acknowledged. SCL then stays low until the host sets the bit, and is freed on the next system clock. A controller NACK ends the read without any stretch.
- R6: In 10-bit mode, a first byte with bits [7:3]=11110 and bits [2:1] equal to own-address bits [2:1] (the host keeps 11110 in own-address bits [7:3]), with bit 0 = 0, is acknowledged and sets `ua_q` and `irq_q`. SCL is held low at the end of the ACK until the own-address register is written. That write clears `ua_q` and frees SCL on the next clock.
- R7: In 10-bit mode, the second address byte is compared with all eight own-address bits. On a match it is acknowledged and `ua_q`, `irq_q` and the clock hold repeat as in R6. On a mismatch it gets no ACK and the transfer is ignored.
- R8: In 10-bit mode, the device counts as selected once both address bytes of a write have matched. If it is selected, a repeated START followed by the first byte with bit 0 = 1 is acknowledged and starts a read as in R4 and R5. A STOP clears the selection, and the same read header then gets no ACK.
- R9: The clock hold starts only while SCL is low. No hold occurs while data bytes are being received with no address update pending.
- R10: A pulse on `irq_clr` clears `irq_q` unless the block sets the flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| scl_oe | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe | output | 1 | 1 pulls SDA low |
| ten_bit_en | input | 1 | 1 selects 10-bit addressing |
| buf_wr | input | 1 | Host write strobe for the data buffer |
| buf_wdata | input | 8 | Host data for the buffer |
| buf_rdata | output | 8 | Data buffer contents |
| adr_wr | input | 1 | Host write strobe for the own-address register |
| adr_wdata | input | 8 | New own-address value |
| rel_set | input | 1 | Sets the clock-release bit |
| rel_q | output | 1 | Clock-release bit |
| ua_q | output | 1 | Address-update needed flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_q | output | 1 | Interrupt flag |
| rw_q | output | 1 | Direction of the current transfer, 1 = read |

## Verification
The bench checks whether SCL is held at each point where a hold may start: after a read address, after a controller ACK, and after each 10-bit write address byte. It also checks that SCL is let go one clock after the host acts. A design that skipped the hardware clear would send stale buffer data, and one that released late would slow every byte. It drives a byte at a wrong address and a wrong second 10-bit byte, followed by data. A matcher that failed to fall idle would acknowledge that data or overwrite the buffer. It also sends a 10-bit read header after a STOP, which a design that kept its selection across STOP would wrongly acknowledge. It ends a read with a NACK, which a design that always stretched after a transmitted byte would turn into a bus hang.

// File: rtl/i2c_ss_pkg.sv
// Shared types and constants for the I2C target with clock hold.
// Assumes byte-wide transfers; the 10-bit header prefix is fixed by the bus.
package i2c_ss_pkg;
    localparam int BYTE_W = 8;
    localparam logic [4:0] TEN_HDR = 5'b11110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADR1,
        PH_ADR2,
        PH_RX,
        PH_TX
    } phase_t;
endpackage

// File: rtl/i2c_ss_line_sync.sv
// Synchronizes SCL and SDA through STAGES flops, then derives SCL edges
// and START/STOP conditions from the synchronized levels.
// Assumes STAGES >= 2; both lines idle high after reset.
module i2c_ss_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] lvl;
    logic              scl_s;
    logic              scl_p;
    logic              sda_p;

    assign raw = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            // Shift the raw line level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign lvl[g] = chain[STAGES-1];
        end
    endgenerate

    assign scl_s = lvl[1];
    assign sda_s = lvl[0];

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_ss_shifter.sv
// Receive shift register with a frame bit counter. Counts SCL rising edges
// from 0 to W+1 (W data bits plus the ACK slot) and shifts SDA in MSB first
// on the first W of them. Assumes clr and rise are never high together.
module i2c_ss_shifter #(
    parameter int W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      rise,
    input  logic                      din,
    output logic [W-1:0]              q,
    output logic [$clog2(W+2)-1:0]    cnt
);
    localparam int CW = $clog2(W + 2);

    // Shift data bits and count clock rises within one byte frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (rise) begin
            if (cnt < CW'(W))  q   <= {q[W-2:0], din};
            if (cnt <= CW'(W)) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_ss_addr_cmp.sv
// Address comparators for a received byte against the own-address register:
// 7-bit match, 10-bit header match and 10-bit low-byte match.
// Assumes the host keeps the header pattern in own[7:3] during 10-bit use.
module i2c_ss_addr_cmp
    import i2c_ss_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] own,
    output logic              hit7,
    output logic              hit_hdr,
    output logic              hit_lo
);
    // Compare the received byte with the register in all three formats.
    always_comb begin
        hit7    = (rx_byte[7:1] == own[6:0]);
        hit_hdr = (rx_byte[7:3] == TEN_HDR) && (rx_byte[2:1] == own[2:1]);
        hit_lo  = (rx_byte == own);
    end
endmodule

// File: rtl/i2c_stretch_slave.sv
// I2C target with 7/10-bit addressing and automatic clock hold.
// Holds SCL low after a read address or controller ACK until the host sets
// the release bit, and after each 10-bit write address byte until the host
// rewrites the own-address register. Assumes open-drain lines resolved
// outside, with 1 on an *_oe output meaning "pull low".
module i2c_stretch_slave
    import i2c_ss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              ten_bit_en,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    output logic [BYTE_W-1:0] buf_rdata,
    input  logic              adr_wr,
    input  logic [BYTE_W-1:0] adr_wdata,
    input  logic              rel_set,
    output logic              rel_q,
    output logic              ua_q,
    input  logic              irq_clr,
    output logic              irq_q,
    output logic              rw_q
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic [CNT_W-1:0]  cnt;
    logic              hit7, hit_hdr, hit_lo;
    logic              byte_fall, frame_end, ack_rise;

    phase_t            phase_q;
    logic [BYTE_W-1:0] buf_q, own_q;
    logic              ckp_q, ua_r, irq_r, rw_r;
    logic              hold_q, ack_drv_q, ten_sel_q, mnack_q;
    logic [CNT_W-1:0]  tx_idx_q;
    logic [BYTE_W-1:0] tx_sh;
    logic              tx_drv;

    i2c_ss_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_fall = scl_fall && (cnt == CNT_BYTE);
    assign frame_end = scl_fall && (cnt == CNT_ACK);
    assign ack_rise  = scl_rise && (cnt == CNT_BYTE);

    i2c_ss_shifter #(.W(BYTE_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_det | frame_end),
        .rise  (scl_rise),
        .din   (sda_s),
        .q     (rx_byte),
        .cnt   (cnt)
    );

    i2c_ss_addr_cmp u_cmp (
        .rx_byte (rx_byte),
        .own     (own_q),
        .hit7    (hit7),
        .hit_hdr (hit_hdr),
        .hit_lo  (hit_lo)
    );

    // Host accesses first; bus events later so hardware wins on a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            buf_q     <= '0;
            own_q     <= '0;
            ckp_q     <= 1'b1;
            ua_r      <= 1'b0;
            irq_r     <= 1'b0;
            rw_r      <= 1'b0;
            hold_q    <= 1'b0;
            ack_drv_q <= 1'b0;
            ten_sel_q <= 1'b0;
            mnack_q   <= 1'b1;
            tx_idx_q  <= CNT_BYTE;
        end else begin
            if (buf_wr)  buf_q <= buf_wdata;
            if (adr_wr) begin
                own_q <= adr_wdata;
                ua_r  <= 1'b0;
            end
            if (rel_set) ckp_q <= 1'b1;
            if (irq_clr) irq_r <= 1'b0;
            if (hold_q && (ckp_q || rel_set) && (!ua_r || adr_wr))
                hold_q <= 1'b0;

            if (stop_det) begin
                phase_q   <= PH_IDLE;
                ten_sel_q <= 1'b0;
                ack_drv_q <= 1'b0;
                tx_idx_q  <= CNT_BYTE;
            end else if (start_det) begin
                phase_q   <= PH_ADR1;
                ack_drv_q <= 1'b0;
                tx_idx_q  <= CNT_BYTE;
            end else if (phase_q != PH_IDLE) begin
                if (ack_rise && phase_q == PH_TX)
                    mnack_q <= sda_s;
                if (scl_fall && phase_q == PH_TX && cnt != '0 && cnt <= CNT_BYTE)
                    tx_idx_q <= cnt;

                if (byte_fall) begin
                    unique case (phase_q)
                        PH_ADR1: begin
                            if (!ten_bit_en) begin
                                if (hit7) begin
                                    ack_drv_q <= 1'b1;
                                    irq_r     <= 1'b1;
                                    rw_r      <= rx_byte[0];
                                    phase_q   <= rx_byte[0] ? PH_TX : PH_RX;
                                end else begin
                                    phase_q <= PH_IDLE;
                                end
                            end else if (hit_hdr && !rx_byte[0]) begin
                                ack_drv_q <= 1'b1;
                                irq_r     <= 1'b1;
                                ua_r      <= 1'b1;
                                rw_r      <= 1'b0;
                                ten_sel_q <= 1'b0;
                                phase_q   <= PH_ADR2;
                            end else if (hit_hdr && rx_byte[0] && ten_sel_q) begin
                                ack_drv_q <= 1'b1;
                                irq_r     <= 1'b1;
                                rw_r      <= 1'b1;
                                phase_q   <= PH_TX;
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end
                        PH_ADR2: begin
                            if (hit_lo) begin
                                ack_drv_q <= 1'b1;
                                irq_r     <= 1'b1;
                                ua_r      <= 1'b1;
                                ten_sel_q <= 1'b1;
                                phase_q   <= PH_RX;
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end
                        PH_RX: begin
                            ack_drv_q <= 1'b1;
                            irq_r     <= 1'b1;
                            buf_q     <= rx_byte;
                        end
                        PH_TX: begin
                            irq_r <= 1'b1;
                        end
                        default: phase_q <= PH_IDLE;
                    endcase
                end

                if (frame_end) begin
                    ack_drv_q <= 1'b0;
                    if (phase_q == PH_TX) begin
                        if (mnack_q) begin
                            phase_q  <= PH_IDLE;
                            tx_idx_q <= CNT_BYTE;
                        end else begin
                            tx_idx_q <= '0;
                            ckp_q    <= 1'b0;
                            hold_q   <= 1'b1;
                        end
                    end else if (ua_r && !adr_wr) begin
                        hold_q <= 1'b1;
                    end
                end
            end
        end
    end

    // Current transmit bit, taken from the buffer at the latched bit index.
    always_comb begin
        tx_sh  = buf_q << tx_idx_q;
        tx_drv = (phase_q == PH_TX) && (tx_idx_q < CNT_BYTE) && !tx_sh[BYTE_W-1];
    end

    assign sda_oe    = ack_drv_q | tx_drv;
    assign scl_oe    = hold_q;
    assign buf_rdata = buf_q;
    assign rel_q     = ckp_q;
    assign ua_q      = ua_r;
    assign irq_q     = irq_r;
    assign rw_q      = rw_r;
endmodule

// File: rtl/i2c_stretch_slave_chk.sv
// Property checker for the I2C target, bound to the top module.
// Assumes the bus environment keeps SCL low while the block holds it.
module i2c_stretch_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic adr_wr,
    input logic rel_set,
    input logic rel_q,
    input logic ua_q,
    input logic irq_q
);
    logic past_ok;

    // Marks that one clock after reset has passed, so history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_HOLD_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !scl_i);                                   // R9
    AST_CLEARED_REL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_q |-> scl_oe);                                          // R5
    AST_REL_FREES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && rel_set && !ua_q) |=> !scl_oe);                   // R5
    AST_ADR_FREES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && adr_wr && rel_q) |=> !scl_oe);                    // R6
    AST_UA_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ua_q) |-> irq_q);                                      // R6
    AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && scl_i && $past(scl_i)) |-> $stable(sda_oe));     // R4
endmodule

bind i2c_stretch_slave i2c_stretch_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .adr_wr  (adr_wr),
    .rel_set (rel_set),
    .rel_q   (rel_q),
    .ua_q    (ua_q),
    .irq_q   (irq_q)
);

// File: tb/i2c_stretch_slave_tb.sv
// Directed bench: a bus-controller model plus host tasks, one task per scenario.
module i2c_stretch_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam int WAIT_MAX   = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic       scl_line, sda_line;
    logic       scl_oe, sda_oe;
    logic       ten_bit_en = 1'b0;
    logic       buf_wr = 1'b0, adr_wr = 1'b0, rel_set = 1'b0, irq_clr = 1'b0;
    logic [7:0] buf_wdata = '0, adr_wdata = '0, buf_rdata;
    logic       rel_q, ua_q, irq_q, rw_q;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_stretch_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .ten_bit_en(ten_bit_en),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .adr_wr(adr_wr), .adr_wdata(adr_wdata), .rel_set(rel_set),
        .rel_q(rel_q), .ua_q(ua_q), .irq_clr(irq_clr), .irq_q(irq_q),
        .rw_q(rw_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        int n = 0;
        while (!scl_line && n < WAIT_MAX) begin
            @(negedge clk);
            n++;
        end
        if (n >= WAIT_MAX) chk("R5", "scl stuck low", 0, 1);
    endtask

    // ---- bus controller model ----
    task automatic m_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0; wait_clks(QTR);
        m_sda_low = 1'b1; wait_clks(QTR);
        m_scl_low = 1'b1; wait_clks(QTR);
    endtask

    task automatic m_rstart();
        m_sda_low = 1'b0; wait_clks(QTR);
        m_scl_low = 1'b0; wait_scl_high(); wait_clks(QTR);
        m_sda_low = 1'b1; wait_clks(QTR);
        m_scl_low = 1'b1; wait_clks(QTR);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; wait_clks(QTR);
        m_scl_low = 1'b0; wait_scl_high(); wait_clks(QTR);
        m_sda_low = 1'b0; wait_clks(QTR);
    endtask

    task automatic m_bit(input logic b, output logic r);
        m_sda_low = !b; wait_clks(QTR);
        m_scl_low = 1'b0; wait_scl_high(); wait_clks(QTR);
        r = sda_line;
        m_scl_low = 1'b1; wait_clks(QTR);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic nack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(d[i], r);
        m_bit(1'b1, nack);
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            m_bit(1'b1, r);
            d = {d[6:0], r};
        end
        m_bit(!give_ack, r);
    endtask

    // ---- host model ----
    task automatic host_buf(input logic [7:0] d);
        @(negedge clk); buf_wr = 1'b1; buf_wdata = d;
        @(negedge clk); buf_wr = 1'b0;
    endtask

    task automatic host_adr(input logic [7:0] a);
        @(negedge clk); adr_wr = 1'b1; adr_wdata = a;
        @(negedge clk); adr_wr = 1'b0;
    endtask

    task automatic host_clr_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic host_rel_chk(input string req);
        @(negedge clk);
        chk(req, "scl held before release", scl_oe, 1);
        rel_set = 1'b1;
        @(negedge clk); rel_set = 1'b0;
        chk(req, "scl freed next clock", scl_oe, 0);
    endtask

    task automatic host_adr_chk(input string req, input logic [7:0] a);
        @(negedge clk);
        chk(req, "scl held before address write", scl_oe, 1);
        adr_wr = 1'b1; adr_wdata = a;
        @(negedge clk); adr_wr = 1'b0;
        chk(req, "scl freed after address write", scl_oe, 0);
        chk(req, "update flag cleared", ua_q, 0);
    endtask

    // ---- scenarios ----
    task automatic t_reset();
        chk("R1", "scl_oe", scl_oe, 0);
        chk("R1", "sda_oe", sda_oe, 0);
        chk("R1", "rel_q", rel_q, 1);
        chk("R1", "ua_q", ua_q, 0);
        chk("R1", "irq_q", irq_q, 0);
        chk("R1", "rw_q", rw_q, 0);
        chk("R1", "buf_rdata", buf_rdata, 0);
    endtask

    task automatic t_write7();
        logic nack;
        ten_bit_en = 1'b0;
        host_adr(8'h5A);
        m_start();
        m_wbyte(8'hB4, nack);
        chk("R2", "ack of matching write address", nack, 0);
        chk("R2", "direction write", rw_q, 0);
        chk("R9", "no hold after write address", scl_oe, 0);
        host_clr_irq();
        m_wbyte(8'hC3, nack);
        chk("R3", "data ack", nack, 0);
        chk("R3", "buffer first byte", buf_rdata, 8'hC3);
        chk("R3", "irq after byte", irq_q, 1);
        host_clr_irq();
        chk("R10", "irq cleared", irq_q, 0);
        m_wbyte(8'h3C, nack);
        chk("R3", "buffer second byte", buf_rdata, 8'h3C);
        chk("R9", "no hold in receive", scl_oe, 0);
        m_stop();
        host_clr_irq();
    endtask

    task automatic t_nomatch7();
        logic nack;
        m_start();
        m_wbyte(8'h22, nack);
        chk("R2", "no ack on mismatch", nack, 1);
        m_wbyte(8'h00, nack);
        chk("R2", "data ignored after mismatch", nack, 1);
        chk("R2", "buffer unchanged", buf_rdata, 8'h3C);
        chk("R2", "irq unchanged", irq_q, 0);
        m_stop();
    endtask

    task automatic t_read7();
        logic nack;
        logic [7:0] d;
        m_start();
        m_wbyte(8'hB5, nack);
        chk("R2", "ack of read address", nack, 0);
        chk("R2", "direction read", rw_q, 1);
        chk("R5", "release bit cleared after read address", rel_q, 0);
        host_clr_irq();
        host_buf(8'hA5);
        host_rel_chk("R5");
        m_rbyte(1'b1, d);
        chk("R4", "first read byte", d, 8'hA5);
        chk("R4", "irq after transmit", irq_q, 1);
        chk("R5", "release bit cleared after controller ack", rel_q, 0);
        host_buf(8'h81);
        host_rel_chk("R5");
        m_rbyte(1'b0, d);
        chk("R4", "second read byte", d, 8'h81);
        wait_clks(QTR);
        chk("R5", "no hold after nack", scl_oe, 0);
        chk("R5", "release bit kept after nack", rel_q, 1);
        m_stop();
        host_clr_irq();
    endtask

    task automatic t_ten_write_read();
        logic nack;
        logic [7:0] d;
        ten_bit_en = 1'b1;
        host_adr(8'hF4);
        m_start();
        m_wbyte(8'hF4, nack);
        chk("R6", "ack of header", nack, 0);
        chk("R6", "update flag set", ua_q, 1);
        chk("R6", "irq with update", irq_q, 1);
        host_adr_chk("R6", 8'h6B);
        m_wbyte(8'h6B, nack);
        chk("R7", "ack of low byte", nack, 0);
        chk("R7", "update flag set again", ua_q, 1);
        host_adr_chk("R7", 8'hF4);
        m_wbyte(8'h77, nack);
        chk("R3", "10-bit data ack", nack, 0);
        chk("R3", "10-bit data in buffer", buf_rdata, 8'h77);
        m_rstart();
        m_wbyte(8'hF5, nack);
        chk("R8", "ack of read header after full match", nack, 0);
        chk("R8", "direction read", rw_q, 1);
        host_buf(8'h3E);
        host_rel_chk("R8");
        m_rbyte(1'b0, d);
        chk("R8", "10-bit read byte", d, 8'h3E);
        m_stop();
        host_clr_irq();
    endtask

    task automatic t_ten_mismatch();
        logic nack;
        m_start();
        m_wbyte(8'hF4, nack);
        chk("R6", "header ack", nack, 0);
        host_adr_chk("R6", 8'h6B);
        m_wbyte(8'h6C, nack);
        chk("R7", "no ack on low byte mismatch", nack, 1);
        chk("R7", "no update flag", ua_q, 0);
        chk("R7", "no hold after mismatch", scl_oe, 0);
        m_wbyte(8'h55, nack);
        chk("R7", "data ignored", nack, 1);
        chk("R7", "buffer unchanged", buf_rdata, 8'h3E);
        m_stop();
        host_adr(8'hF4);
        m_start();
        m_wbyte(8'hF5, nack);
        chk("R8", "no ack of read header after stop", nack, 1);
        m_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);
        t_reset();
        t_write7();
        t_nomatch7();
        t_read7();
        t_ten_write_read();
        t_ten_mismatch();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end
endmodule